// File: doc/BRIEF.md
# Indexed Real-Time-Clock Register Port

This block is the register front end of a real-time clock. A host reaches its 128 bytes of storage through two addresses. A write to the even address chooses which byte is current, and an access to the odd address reads or writes that byte. The storage holds four control bytes, the time, date and alarm bytes, and general-purpose memory. Several control bytes have side effects: some bits are read-only, one byte is never written, and one byte holds interrupt flags that clear when the host reads them.

A separate calendar block does the timekeeping. It raises flag bits and the update-in-progress bit, writes time bytes back, and reads any byte through its own read index. This block sends it a reload pulse whenever the host loads new time values. A sideband write port feeds the configuration area. Each accepted sideband write into the checksummed range starts a walk over that range, and the walk stores a 16-bit additive checksum in two fixed bytes.

The sideband port is valid/ready. A transfer happens on a rising edge where `sb_valid` and `sb_ready` are both high. `sb_ready` is low while a checksum walk is running and in any cycle in which the host writes through the odd address. The sender must hold `sb_valid`, `sb_idx` and `sb_wdata` steady until the transfer happens.

Top module: `rtc_regfile_port`

## Requirements
- R1: After reset, control byte A (index 10) reads 0x26, B (index 11) reads 0x02, C (index 12) reads 0x00 and D (index 13) reads 0x80. `irq` and `time_reload` are low, and every other byte reads 0x00.
- R2: A host write with `host_addr`=0 makes bits 6:0 of the data the current index and discards bit 7. A host read with `host_addr`=0 returns 0xFF. Read data appears on `host_rdata` in the cycle after the read strobe and holds until the next read.
- R3: A host access with `host_addr`=1 reads or writes the byte at the current index. This covers general storage and the alarm bytes at indices 1, 3 and 5.
- R4: A host write to byte A keeps bit 7 (update in progress) and takes bits 6:0 from the data. Bit 7 is set by `cal_uip_set` and cleared by `cal_uip_clr`.
- R5: Writes to bytes C and D from the host, sideband or calendar port are ignored.
- R6: Any nonzero `cal_flags` is ORed into byte C and raises `irq`. A host read of C returns its value, then clears C and drops `irq`.
- R7: When `cal_flags` is nonzero in the same cycle as a host read of C, the read returns the old value. C then holds the new flags and `irq` stays high.
- R8: A host write to a time or date byte (indices 0, 2, 4, 6, 7, 8, 9) while SET (bit 7 of byte B) is clear pulses `time_reload` for one cycle, in the next cycle. The pulse does not occur when SET is set, and never for alarm bytes.
- R9: A host write to B with bit 7 set clears bit 7 of byte A. A host write to B with bit 7 clear, while SET was set, pulses `time_reload`.
- R10: An accepted sideband write into indices 0x10 to 0x2D stores bits 15:8 of the sum of those bytes at 0x2E and bits 7:0 at 0x2F. Both bytes are written 30 cycles after the transfer. Sideband writes to other indices store the byte and start no walk.
- R11: `sb_ready` is low during a checksum walk and in any cycle with a host write through the odd address. Otherwise it is high.
- R12: A calendar write (`cal_wr`) stores `cal_wdata` at `cal_idx`. `cal_rdata` always shows the byte at `cal_ridx`, and `ctrl_a` and `ctrl_b` always show bytes A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = index address, 1 = data address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt line |
| cal_wr | input | 1 | Calendar byte write strobe |
| cal_idx | input | 7 | Calendar write index |
| cal_wdata | input | 8 | Calendar write data |
| cal_flags | input | 8 | Flag bits to OR into byte C |
| cal_uip_set | input | 1 | Set update-in-progress |
| cal_uip_clr | input | 1 | Clear update-in-progress |
| cal_ridx | input | 7 | Calendar read index |
| cal_rdata | output | 8 | Byte at `cal_ridx` |
| ctrl_a | output | 8 | Current byte A |
| ctrl_b | output | 8 | Current byte B |
| time_reload | output | 1 | One-cycle request to reload time from storage |
| sb_valid | input | 1 | Sideband write valid |
| sb_ready | output | 1 | Sideband write ready |
| sb_idx | input | 7 | Sideband write index |
| sb_wdata | input | 8 | Sideband write data |

## Verification
Three results follow one rising edge after the strobe that causes them: `host_rdata`, `irq` and `time_reload`. The same holds for every byte written to storage. The checksum bytes follow 30 edges after the sideband transfer, and `sb_ready` follows its inputs in the same cycle. A behavioural model in the bench steps on every rising edge with the same inputs. All outputs are compared 1 ns after each falling edge, which is after the model and the design have both settled and the driver has applied new inputs. Directed reads also check literal values derived from the requirements at the same sampling point.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam int IDX_SEC   = 0;
  localparam int IDX_A     = 10;
  localparam int IDX_B     = 11;
  localparam int IDX_C     = 12;
  localparam int IDX_D     = 13;
  localparam int CS_FIRST  = 16;
  localparam int CS_LAST   = 45;
  localparam int CS_HI     = 46;
  localparam int CS_LO     = 47;
  localparam logic [7:0] RST_A = 8'h26;
  localparam logic [7:0] RST_B = 8'h02;
  localparam logic [7:0] RST_C = 8'h00;
  localparam logic [7:0] RST_D = 8'h80;

  // bytes that carry time or date and trigger a reload when written
  function automatic logic is_time_byte(input int idx);
    return (idx == 0) || (idx == 2) || (idx == 4) || (idx >= 6 && idx <= 9);
  endfunction

  // bytes no port may write
  function automatic logic is_locked_byte(input int idx);
    return (idx == IDX_C) || (idx == IDX_D);
  endfunction

  function automatic logic in_csum_range(input int idx);
    return (idx >= CS_FIRST) && (idx <= CS_LAST);
  endfunction
endpackage

// File: rtl/rtc_host_decode.sv
module rtc_host_decode #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [AW-1:0] cur_idx,
  output logic          data_wr,
  output logic          data_rd,
  output logic          index_rd
);
  assign data_wr  = host_wr && host_addr;
  assign data_rd  = host_rd && host_addr;
  assign index_rd = host_rd && !host_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_idx <= '0;
    else if (host_wr && !host_addr) cur_idx <= host_wdata[AW-1:0];
  end
endmodule

// File: rtl/rtc_csum_walker.sv
module rtc_csum_walker #(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int FIRST = 16,
  parameter int LAST  = 45
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   rd_byte,
  output logic [AW-1:0]   rd_idx,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] sum
);
  logic [2*DW-1:0] acc;

  assign done = busy && (rd_idx == AW'(LAST));
  assign sum  = acc + {{DW{1'b0}}, rd_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rd_idx <= AW'(FIRST);
      acc    <= '0;
    end else if (busy) begin
      acc    <= sum;
      rd_idx <= rd_idx + 1'b1;
      if (done) busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      rd_idx <= AW'(FIRST);
      acc    <= '0;
    end
  end

  p_walk_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/rtc_regfile_port.sv
module rtc_regfile_port
  import rtc_port_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic                     host_addr,
  input  logic [DW-1:0]            host_wdata,
  output logic [DW-1:0]            host_rdata,
  output logic                     irq,
  input  logic                     cal_wr,
  input  logic [$clog2(DEPTH)-1:0] cal_idx,
  input  logic [DW-1:0]            cal_wdata,
  input  logic [DW-1:0]            cal_flags,
  input  logic                     cal_uip_set,
  input  logic                     cal_uip_clr,
  input  logic [$clog2(DEPTH)-1:0] cal_ridx,
  output logic [DW-1:0]            cal_rdata,
  output logic [DW-1:0]            ctrl_a,
  output logic [DW-1:0]            ctrl_b,
  output logic                     time_reload,
  input  logic                     sb_valid,
  output logic                     sb_ready,
  input  logic [$clog2(DEPTH)-1:0] sb_idx,
  input  logic [DW-1:0]            sb_wdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int TOP_BIT = DW - 1;

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   cur_idx;
  logic            data_wr, data_rd, index_rd;
  logic [AW-1:0]   walk_idx;
  logic            walk_busy, walk_done;
  logic [2*DW-1:0] walk_sum;
  logic            sb_fire, c_read;

  rtc_host_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .cur_idx(cur_idx),
    .data_wr(data_wr), .data_rd(data_rd), .index_rd(index_rd)
  );

  assign sb_ready = !walk_busy && !data_wr;
  assign sb_fire  = sb_valid && sb_ready;
  assign c_read   = data_rd && (cur_idx == AW'(IDX_C));

  rtc_csum_walker #(.AW(AW), .DW(DW), .FIRST(CS_FIRST), .LAST(CS_LAST)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(sb_fire && in_csum_range(int'(sb_idx))),
    .rd_byte(mem[walk_idx]), .rd_idx(walk_idx), .busy(walk_busy),
    .done(walk_done), .sum(walk_sum)
  );

  assign cal_rdata = mem[cal_ridx];
  assign ctrl_a    = mem[IDX_A];
  assign ctrl_b    = mem[IDX_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      mem[IDX_A]  <= RST_A;
      mem[IDX_B]  <= RST_B;
      mem[IDX_C]  <= RST_C;
      mem[IDX_D]  <= RST_D;
      host_rdata  <= '0;
      irq         <= 1'b0;
      time_reload <= 1'b0;
    end else begin
      time_reload <= 1'b0;
      if (index_rd)     host_rdata <= '1;
      else if (data_rd) host_rdata <= mem[cur_idx];

      if (cal_wr && !is_locked_byte(int'(cal_idx))) mem[cal_idx] <= cal_wdata;
      if (sb_fire && !is_locked_byte(int'(sb_idx))) mem[sb_idx] <= sb_wdata;

      if (data_wr) begin
        if (cur_idx == AW'(IDX_A)) begin
          mem[IDX_A] <= {mem[IDX_A][TOP_BIT], host_wdata[TOP_BIT-1:0]};
        end else if (cur_idx == AW'(IDX_B)) begin
          if (host_wdata[TOP_BIT])        mem[IDX_A][TOP_BIT] <= 1'b0;
          else if (mem[IDX_B][TOP_BIT])   time_reload <= 1'b1;
          mem[IDX_B] <= host_wdata;
        end else if (!is_locked_byte(int'(cur_idx))) begin
          mem[cur_idx] <= host_wdata;
          if (is_time_byte(int'(cur_idx)) && !mem[IDX_B][TOP_BIT]) time_reload <= 1'b1;
        end
      end

      if (cal_uip_set)      mem[IDX_A][TOP_BIT] <= 1'b1;
      else if (cal_uip_clr) mem[IDX_A][TOP_BIT] <= 1'b0;

      if (c_read)          mem[IDX_C] <= cal_flags;
      else if (|cal_flags) mem[IDX_C] <= mem[IDX_C] | cal_flags;

      if (|cal_flags)  irq <= 1'b1;
      else if (c_read) irq <= 1'b0;

      if (walk_done) begin
        mem[CS_HI] <= walk_sum[2*DW-1:DW];
        mem[CS_LO] <= walk_sum[DW-1:0];
      end
    end
  end

  p_index_read_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_addr) |=> (host_rdata == '1));
  p_uip_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_idx == AW'(IDX_A) && !cal_uip_set && !cal_uip_clr)
      |=> (mem[IDX_A][TOP_BIT] == $past(mem[IDX_A][TOP_BIT])));
  p_d_unwritable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && cur_idx == AW'(IDX_D)) |=> $stable(mem[IDX_D]));
  p_c_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_read && cal_flags == '0) |=> (mem[IDX_C] == '0 && !irq));
  p_flag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_flags != '0) |=> irq);
  p_reload_set_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    time_reload |-> !ctrl_b[TOP_BIT]);
  p_walk_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_fire && in_csum_range(int'(sb_idx))) |=> !sb_ready);
endmodule

// File: tb/test_rtc_regfile_port.sv
module test_rtc_regfile_port;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic irq, cal_wr = 0, cal_uip_set = 0, cal_uip_clr = 0;
  logic [6:0] cal_idx = 0, cal_ridx = 0, sb_idx = 0;
  logic [7:0] cal_wdata = 0, cal_flags = 0, cal_rdata, ctrl_a, ctrl_b, sb_wdata = 0;
  logic time_reload, sb_valid = 0, sb_ready;

  always #4 clk = ~clk;

  rtc_regfile_port i_rtc_regfile_port (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .cal_wr(cal_wr), .cal_idx(cal_idx), .cal_wdata(cal_wdata),
    .cal_flags(cal_flags), .cal_uip_set(cal_uip_set), .cal_uip_clr(cal_uip_clr),
    .cal_ridx(cal_ridx), .cal_rdata(cal_rdata), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .time_reload(time_reload), .sb_valid(sb_valid), .sb_ready(sb_ready),
    .sb_idx(sb_idx), .sb_wdata(sb_wdata)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m[128];
  int m_idx, m_rdata, wcnt;
  bit m_irq, m_rel;

  function automatic bit is_time(int i);
    return i == 0 || i == 2 || i == 4 || (i >= 6 && i <= 9);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      m[10] = 'h26; m[11] = 'h02; m[13] = 'h80;
      m_idx = 0; m_rdata = 0; m_irq = 0; m_rel = 0; wcnt = 0;
    end else begin
      bit rdy, crd, put_sum;
      int s;
      rdy = (wcnt == 0) && !(host_wr && host_addr);
      put_sum = 0; s = 0;
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          for (int i = 16; i <= 45; i++) s += m[i];
          put_sum = 1;
        end
      end
      m_rel = 0;
      crd = host_rd && host_addr && m_idx == 12;
      if (host_rd) m_rdata = host_addr ? m[m_idx] : 'hFF;
      if (cal_wr && cal_idx != 12 && cal_idx != 13) m[cal_idx] = cal_wdata;
      if (sb_valid && rdy) begin
        if (sb_idx != 12 && sb_idx != 13) m[sb_idx] = sb_wdata;
        if (sb_idx >= 16 && sb_idx <= 45) wcnt = 30;
      end
      if (host_wr && !host_addr) m_idx = host_wdata & 'h7F;
      else if (host_wr) begin
        if (m_idx == 10) m[10] = (m[10] & 'h80) | (host_wdata & 'h7F);
        else if (m_idx == 11) begin
          if (host_wdata[7]) m[10] &= 'h7F;
          else if (m[11] & 'h80) m_rel = 1;
          m[11] = host_wdata;
        end else if (m_idx != 12 && m_idx != 13) begin
          if (is_time(m_idx) && !(m[11] & 'h80)) m_rel = 1;
          m[m_idx] = host_wdata;
        end
      end
      if (cal_uip_set) m[10] |= 'h80;
      else if (cal_uip_clr) m[10] &= 'h7F;
      if (crd) m[12] = cal_flags;
      else m[12] |= cal_flags;
      if (cal_flags != 0) m_irq = 1;
      else if (crd) m_irq = 0;
      if (put_sum) begin m[46] = (s >> 8) & 'hFF; m[47] = s & 'hFF; end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R2 R3 rdata", host_rdata, m_rdata);
      chk("R6 irq", irq, m_irq);
      chk("R8 R9 reload", time_reload, m_rel);
      chk("R11 ready", sb_ready, (wcnt == 0) && !(host_wr && host_addr));
      chk("R4 ctrl_a", ctrl_a, m[10]);
      chk("R12 ctrl_b", ctrl_b, m[11]);
      chk("R12 cal_rdata", cal_rdata, m[cal_ridx]);
    end
  end

  task automatic hwrite(input bit a, input int d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = 8'(d);
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hread(input bit a);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic read_at(input int idx, input int exp, input string tag);
    hwrite(0, idx); hread(1); #1 chk(tag, host_rdata, exp);
  endtask

  task automatic sb_send(input int idx, input int d);
    bit acc;
    @(negedge clk); sb_valid = 1; sb_idx = 7'(idx); sb_wdata = 8'(d);
    do begin #1 acc = sb_ready; @(negedge clk); end while (!acc);
    sb_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    read_at(10, 'h26, "R1 A"); read_at(11, 'h02, "R1 B");
    read_at(12, 'h00, "R1 C"); read_at(13, 'h80, "R1 D");
    read_at(64, 'h00, "R1 storage"); chk("R1 irq", irq, 0);
    // R2 index port
    hread(0); #1 chk("R2 even read", host_rdata, 'hFF);
    hwrite(0, 'h8A); hread(1); #1 chk("R2 index bit7 dropped", host_rdata, 'h26);
    // R3 storage and alarm byte
    hwrite(0, 'h50); hwrite(1, 'h5A); read_at('h50, 'h5A, "R3 storage");
    hwrite(0, 3); hwrite(1, 'h45); read_at(3, 'h45, "R3 alarm");
    // R4 update-in-progress bit kept
    @(negedge clk); cal_uip_set = 1; @(negedge clk); cal_uip_set = 0;
    hwrite(0, 10); hwrite(1, 'h05); read_at(10, 'h85, "R4 uip kept set");
    @(negedge clk); cal_uip_clr = 1; @(negedge clk); cal_uip_clr = 0;
    hwrite(0, 10); hwrite(1, 'hAA); read_at(10, 'h2A, "R4 uip kept clear");
    // R5 C and D not writable
    hwrite(0, 12); hwrite(1, 'h55); read_at(12, 'h00, "R5 C");
    hwrite(0, 13); hwrite(1, 'h00); read_at(13, 'h80, "R5 D");
    sb_send(13, 'h11); read_at(13, 'h80, "R5 D sideband");
    // R6 flags and clear on read
    @(negedge clk); cal_flags = 'h90; @(negedge clk); cal_flags = 0;
    #1 chk("R6 irq raised", irq, 1);
    read_at(12, 'h90, "R6 C value"); chk("R6 irq dropped", irq, 0);
    read_at(12, 'h00, "R6 C cleared");
    // R7 flag arriving with the read
    @(negedge clk); cal_flags = 'h20; @(negedge clk); cal_flags = 0;
    hwrite(0, 12);
    @(negedge clk); host_rd = 1; host_addr = 1; cal_flags = 'hA0;
    @(negedge clk); host_rd = 0; cal_flags = 0;
    #1 chk("R7 old value", host_rdata, 'h20); chk("R7 irq held", irq, 1);
    read_at(12, 'hA0, "R7 new flag kept");
    // R8 reload on time write
    hwrite(0, 0); @(negedge clk); host_wr = 1; host_addr = 1; host_wdata = 'h30;
    @(negedge clk); host_wr = 0; #1 chk("R8 reload pulse", time_reload, 1);
    hwrite(0, 1); hwrite(1, 'h12); #1 chk("R8 alarm no reload", time_reload, 0);
    // R9 SET handling
    @(negedge clk); cal_uip_set = 1; @(negedge clk); cal_uip_set = 0;
    hwrite(0, 11); hwrite(1, 'h82); #1 chk("R9 uip cleared by SET", ctrl_a[7], 0);
    hwrite(0, 2); hwrite(1, 'h15); #1 chk("R8 no reload under SET", time_reload, 0);
    hwrite(0, 11); @(negedge clk); host_wr = 1; host_addr = 1; host_wdata = 'h02;
    @(negedge clk); host_wr = 0; #1 chk("R9 reload on SET clear", time_reload, 1);
    // R12 calendar ports
    @(negedge clk); cal_wr = 1; cal_idx = 'h40; cal_wdata = 'h77;
    @(negedge clk); cal_wr = 0; cal_ridx = 'h40;
    #1 chk("R12 cal_rdata", cal_rdata, 'h77);
    read_at('h40, 'h77, "R12 host sees cal write");
    // R10 checksum walk
    sb_send('h10, 'hFF); #1 chk("R11 busy after start", sb_ready, 0);
    repeat (31) @(negedge clk);
    sb_send('h2D, 'hF0); repeat (31) @(negedge clk);
    sb_send('h20, 'h12); repeat (31) @(negedge clk);
    read_at('h2E, 'h02, "R10 checksum high");
    read_at('h2F, 'h01, "R10 checksum low");
    sb_send('h60, 'h33); #1 chk("R10 no walk outside range", sb_ready, 1);
    read_at('h60, 'h33, "R10 outside byte stored");
    // R11 host write blocks sideband
    hwrite(0, 'h50);
    @(negedge clk); sb_valid = 1; sb_idx = 'h61; sb_wdata = 'h44;
    host_wr = 1; host_addr = 1; host_wdata = 'h66;
    #1 chk("R11 ready low on host write", sb_ready, 0);
    @(negedge clk); host_wr = 0; #1 chk("R11 ready back", sb_ready, 1);
    @(negedge clk); sb_valid = 0;
    read_at('h61, 'h44, "R11 delayed transfer");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule